// File: doc/BRIEF.md
# Byte Queue with Overflow Error Pulse

This block is a sixteen-deep, byte-wide first-in first-out store that sits between a host register port and a SCSI-side data path. Either side pushes bytes into it and pops them back out in arrival order. The oldest byte is always shown on the head output, so a pop takes the byte that is visible in the same cycle. The number of stored bytes is reported on its own and also in the low bits of an eight-bit flags word.

A push into a full queue does not drop data silently. It replaces the newest byte and emits a one-cycle gross-error pulse, which the neighbouring status unit latches. A pop on an empty queue has no effect, and the head then reads zero. A flush, or a chip-level hard clear, zeroes the whole store and the count. Both leave the upper three bits of the flags word alone. Those upper bits are loaded through a separate tag write.

Top module: `byte_fifo_ge`

## Requirements
- R1: After the asynchronous reset, head_o is 0x00, count_o is 0, flags_o is 0x00 and gross_err_o is 0.
- R2: Bytes leave in the order they were pushed, and head_o always shows the oldest stored byte.
- R3: count_o, which equals flags_o[4:0], goes up by one on an accepted push and down by one on an accepted pop, and never exceeds 16.
- R4: A push alone while 16 bytes are held leaves the count at 16 and replaces the newest (sixteenth) byte with the pushed data.
- R5: A pop while the count is zero leaves the count at zero, and head_o reads 0x00.
- R6: Popping the last stored byte leaves head_o at 0x00, because the vacated entry is zero-filled.
- R7: A push and a pop in the same cycle on a queue that is neither empty nor full keep the count. The old head leaves, and the new byte joins at the tail.
- R8: A push and a pop in the same cycle on a full queue keep the count at 16 and raise no gross error.
- R9: flush_i zeroes every entry and the count in the following cycle, takes priority over a push or pop in the same cycle, and keeps flags_o[7:5].
- R10: hard_clr_i has exactly the same effect as flush_i.
- R11: tag_wr_i loads tag_data_i into flags_o[7:5] on the next edge. Otherwise those bits hold, including across a flush or a hard clear.
- R12: gross_err_o is high for exactly the cycle that follows each overflowing push. Back-to-back overflowing pushes give one high cycle per push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push push_data_i this cycle |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop the head byte this cycle |
| flush_i | input | 1 | Flush command: clear the store and the count |
| hard_clr_i | input | 1 | Chip hard clear: same effect as a flush |
| tag_wr_i | input | 1 | Load the upper flags bits |
| tag_data_i | input | 3 | Value for flags_o[7:5] |
| head_o | output | 8 | Oldest stored byte, or 0x00 when empty |
| count_o | output | 5 | Number of stored bytes |
| flags_o | output | 8 | Tag bits in [7:5], count in [4:0] |
| gross_err_o | output | 1 | One-cycle pulse after an overflowing push |

## Verification
The embedded assertions check on every cycle that the count stays in range and that it holds on overflow, on a pop of an empty queue and on a combined push and pop. They also check that a clear always wins, that the tag bits survive a clear, that the error pulse only follows a push into a full queue, and that the head reads zero after the last pop. Only the bench scenarios can show the data itself. That covers the ordering of bytes through the queue, the replacement of the newest byte on overflow, and the head reading zero after a flush. Each of these is checked against a behavioural queue model on every clock.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 8;

  // per-cycle operation decoded by the controller for the storage array
  typedef struct packed {
    logic clr;    // zero every entry
    logic shift;  // move entries one place toward the head
    logic wr;     // write the pushed byte at the write index
  } store_op_t;
endpackage

// File: rtl/bfifo_store.sv
module bfifo_store
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  store_op_t       op,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   head
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic          mem_en [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] above;
    if (i == DEPTH - 1) begin : g_top
      assign above = '0;              // tail fills with zero on a shift
    end else begin : g_mid
      assign above = mem_q[i+1];
    end

    always_comb begin
      mem_en[i] = op.clr | op.shift | (op.wr && (wr_idx == IDX_W'(i)));
      if (op.clr) begin
        mem_d[i] = '0;
      end else if (op.wr && (wr_idx == IDX_W'(i))) begin
        mem_d[i] = wr_data;
      end else if (op.shift) begin
        mem_d[i] = above;
      end else begin
        mem_d[i] = mem_q[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (mem_en[i]) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end

  assign head = mem_q[0];

endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic             hard_clr,
  output store_op_t        op,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] count,
  output logic             gross_err
);

  logic [CNT_W-1:0] count_q, count_d;
  logic             err_q, err_d;
  logic             empty, full, clr, pop_ok, ovf, grow;
  logic [CNT_W-1:0] slot;

  always_comb begin
    empty  = (count_q == '0);
    full   = (count_q == CNT_W'(DEPTH));
    clr    = flush | hard_clr;
    pop_ok = pop && !empty && !clr;
    ovf    = push && full && !pop && !clr;
    grow   = push && !clr && !ovf;
    slot   = count_q - CNT_W'(pop_ok);
    wr_idx = ovf ? IDX_W'(DEPTH - 1) : slot[IDX_W-1:0];
    op.clr   = clr;
    op.shift = pop_ok;
    op.wr    = grow | ovf;
    if (clr) begin
      count_d = '0;
    end else begin
      count_d = count_q + CNT_W'(grow) - CNT_W'(pop_ok);
    end
    err_d = ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      err_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      err_q   <= err_d;
    end
  end

  assign count     = count_q;
  assign gross_err = err_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));
  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && !hard_clr && count_q == CNT_W'(DEPTH))
    |=> (count_q == CNT_W'(DEPTH)) && gross_err);
  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && !hard_clr && count_q == '0) |=> count_q == '0);
  // R7
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush && !hard_clr && count_q != '0 && count_q != CNT_W'(DEPTH))
    |=> $stable(count_q));
  // R8
  full_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush && !hard_clr && count_q == CNT_W'(DEPTH))
    |=> (count_q == CNT_W'(DEPTH)) && !gross_err);
  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || hard_clr) |=> (count_q == '0) && !gross_err);
  // R12
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gross_err) |-> $past(push && full));

endmodule

// File: rtl/byte_fifo_ge.sv
module byte_fifo_ge
  import bfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = BYTE_W,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int TAG_W = FLAG_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DW-1:0]     push_data_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic              hard_clr_i,
  input  logic              tag_wr_i,
  input  logic [TAG_W-1:0]  tag_data_i,
  output logic [DW-1:0]     head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              gross_err_o
);

  localparam int IDX_W = $clog2(DEPTH);

  store_op_t        op;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] tag_q, tag_d;

  bfifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_i),
    .pop       (pop_i),
    .flush     (flush_i),
    .hard_clr  (hard_clr_i),
    .op        (op),
    .wr_idx    (wr_idx),
    .count     (count_o),
    .gross_err (gross_err_o)
  );

  bfifo_store #(.DEPTH(DEPTH), .DW(DW), .IDX_W(IDX_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .wr_idx  (wr_idx),
    .wr_data (push_data_i),
    .head    (head_o)
  );

  always_comb begin
    tag_d = tag_wr_i ? tag_data_i : tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_wr_i) begin
      tag_q <= tag_d;
    end
  end

  assign flags_o = {tag_q, count_o};

  // R11
  tag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_wr_i |=> $stable(flags_o[FLAG_W-1:CNT_W]));
  // R6
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && count_o == CNT_W'(1)) |=> head_o == '0);

endmodule

// File: tb/test_byte_fifo_ge.sv
module test_byte_fifo_ge;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_i, pop_i, flush_i, hard_clr_i, tag_wr_i;
  logic [7:0] push_data_i;
  logic [2:0] tag_data_i;
  logic [7:0] head_o;
  logic [4:0] count_o;
  logic [7:0] flags_o;
  logic       gross_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] mq[$];
  logic [2:0] m_tag;
  logic       m_err;

  always #2 clk = ~clk;

  byte_fifo_ge i_byte_fifo_ge (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .flush_i(flush_i), .hard_clr_i(hard_clr_i),
    .tag_wr_i(tag_wr_i), .tag_data_i(tag_data_i), .head_o(head_o),
    .count_o(count_o), .flags_o(flags_o), .gross_err_o(gross_err_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    logic [7:0] eh;
    eh = (mq.size() > 0) ? mq[0] : 8'h00;
    chk(req, "head",  head_o, eh);
    chk(req, "count", count_o, mq.size());
    chk(req, "flags", flags_o, {m_tag, 5'(mq.size())});
    chk(req, "gross_err", gross_err_o, m_err);
  endtask

  // drive one cycle, update the model at the edge, compare after it
  task automatic step(string req, bit pu, logic [7:0] d, bit po,
                      bit fl = 0, bit hc = 0, bit tw = 0, logic [2:0] td = 0);
    bit ovf;
    push_i = pu; push_data_i = d; pop_i = po; flush_i = fl;
    hard_clr_i = hc; tag_wr_i = tw; tag_data_i = td;
    @(posedge clk);
    if (tw) m_tag = td;
    if (fl || hc) begin
      mq.delete();
      m_err = 0;
    end else begin
      ovf = pu && !po && (mq.size() == 16);
      if (po && mq.size() > 0) void'(mq.pop_front());
      if (pu) begin
        if (ovf) mq[15] = d;
        else mq.push_back(d);
      end
      m_err = ovf;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 0; push_i = 0; pop_i = 0; flush_i = 0; hard_clr_i = 0;
    tag_wr_i = 0; push_data_i = 0; tag_data_i = 0;
    m_tag = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst_n = 1;

    // R3 / R2: basic pushes and pops
    step("R3", 1, 8'hA1, 0);
    step("R3", 1, 8'hA2, 0);
    step("R3", 1, 8'hA3, 0);
    step("R2", 0, 8'h00, 1);
    step("R7", 1, 8'hA4, 1);
    step("R2", 0, 8'h00, 1);
    step("R6", 0, 8'h00, 1);
    step("R5", 0, 8'h00, 1);
    step("R5", 0, 8'h00, 1);

    // R4 / R12 / R8: fill, overflow twice, combined on full, drain
    for (int i = 0; i < 16; i++) step("R3", 1, 8'(8'h10 + i), 0);
    step("R4", 1, 8'hE1, 0);
    step("R12", 1, 8'hE2, 0);
    step("R12", 0, 8'h00, 0);
    step("R8", 1, 8'hF0, 1);
    for (int i = 0; i < 16; i++) step("R4", 0, 8'h00, 1);
    step("R6", 0, 8'h00, 1);

    // R11 / R9 / R10: tag bits, flush and hard clear
    step("R11", 0, 8'h00, 0, 0, 0, 1, 3'b101);
    for (int i = 0; i < 5; i++) step("R3", 1, 8'(8'h30 + i), 0);
    step("R9", 1, 8'h77, 1, 1);
    step("R11", 0, 8'h00, 1);
    for (int i = 0; i < 16; i++) step("R3", 1, 8'(8'h50 + i), 0);
    step("R10", 1, 8'h88, 0, 0, 1, 1, 3'b010);
    step("R11", 1, 8'h99, 0, 0, 1);
    step("R11", 0, 8'h00, 0, 1, 0, 1, 3'b111);

    // R2: pseudo-random mix
    lfsr = 8'h5B;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step("R2", lfsr[0] | lfsr[3], lfsr ^ 8'(i), lfsr[1],
           (lfsr == 8'hC3), 0, lfsr[7] & lfsr[6] & lfsr[2], lfsr[5:3]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule